// File: doc/BRIEF.md
# Linked-Tag Set Directory

This block is the tag directory of a last-level cache whose sets do not have a fixed associativity. Every set owns a small group of primary ways that are all compared in one cycle. When a set has used all of its primary ways, it does not evict one of its lines. Instead it borrows a tag from a pool shared by all sets and links that tag into a per-set chain. A lookup first compares the primary ways and then follows the chain one borrowed tag per cycle. It reports a hit only when a tag matches, and a miss only after the end of the chain. Each tag holds an indirect pointer to a data slot, and a hit returns that pointer, so the data access comes after the tag match. The directory holds more tags than the data store has slots. The caller chooses the slot pointers.

A caller issues one command at a time: lookup, insert or remove, each with a line address. The command is accepted when `req_ready` is high. It completes with a single-cycle `done` pulse that carries a status code and a slot pointer. Insert does not check for duplicates, so the caller inserts only after a lookup miss. Remove unlinks a borrowed tag from its chain and returns the tag to the pool. Data storage, compression and victim choice belong to other blocks.

Top module: `linked_tag_dir`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `pool_dry` is 0, and every lookup misses.
- R2: The set index is the low log2(SETS) bits of `req_addr`, and the remaining upper bits form the tag. A line inserted in one set is never found by a lookup of the same tag in another set.
- R3: An insert into a set with an invalid primary way fills the lowest-numbered invalid way, reports status 0 and takes no tag from the pool.
- R4: An insert into a set whose primary ways are all valid takes a tag from the pool and places it at the front of the chain. Chain position 1 is therefore always the most recently borrowed tag.
- R5: A lookup (`req_op` 0, or 3, which behaves the same) reports status 0 with the matching tag's slot pointer on `rsp_slot` when a tag matches. Otherwise it reports status 1 (miss).
- R6: Done latency, counted in clock edges after the accepting edge, is as follows. A command decided in the primary ways takes 1 edge. A match at chain position k takes 1+k edges. A miss in a set with chain length L takes 1+L edges.
- R7: An insert that needs a borrowed tag, into a set whose chain already holds MAX_CHAIN tags, reports status 3 and changes nothing.
- R8: `pool_dry` is 1 exactly while every pool tag is linked into some chain. An insert that needs a borrowed tag at that time reports status 2 and changes nothing.
- R9: A remove (`req_op` 2) of a present line reports status 0 with its slot pointer and invalidates it. A remove of an absent line reports status 1.
- R10: Removing a borrowed tag unlinks it at the head or in the middle of its chain and returns it to the pool. The tags after it move up one position, and `pool_dry` falls.
- R11: `req_ready` is 1 only while no command is in progress, and a request presented while it is 0 is ignored. `done` never stays high for two consecutive cycles.
- R12: No command stays in progress for more than MAX_CHAIN+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Engine idle; command accepted on this edge if valid |
| req_op | input | 2 | 0 lookup, 1 insert, 2 remove, 3 lookup |
| req_addr | input | ADDR_W | Line address: set in low bits, tag above |
| req_slot | input | SLOT_W | Data slot pointer stored by an insert |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok/hit, 1 miss, 2 no free tag, 3 chain at limit |
| rsp_slot | output | SLOT_W | Slot pointer of the matched, inserted or removed line |
| pool_dry | output | 1 | No free tag left in the shared pool |

## Verification
The hardest case to reach from the ports is unlinking a borrowed tag from the middle of a chain while the pool is exhausted. The walk must then patch a predecessor's pointer rather than the set's head, and the freed tag must be reused by another set. The stimulus fills two sets to the chain limit, which drains the pool. It then removes a middle entry and a head entry and lets a third set borrow the freed tag. Done latencies measured before and after each removal show the position of every surviving tag.

// File: rtl/ltd_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the linked-tag set directory.
// Assumes: all users import this package; codes are fixed by the port contract.
package ltd_pkg;

    // Engine phase: waiting, comparing primary ways, or walking a chain.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_PRIMARY = 2'd1,
        PH_WALK    = 2'd2
    } phase_e;

    localparam logic [1:0] OP_INSERT = 2'd1;
    localparam logic [1:0] OP_REMOVE = 2'd2;

    localparam logic [1:0] ST_OK        = 2'd0;
    localparam logic [1:0] ST_MISS      = 2'd1;
    localparam logic [1:0] ST_NOSPACE   = 2'd2;
    localparam logic [1:0] ST_CHAINFULL = 2'd3;

endpackage

// File: rtl/ltd_way_match.sv
`timescale 1ns/1ps
// Compares one set's primary ways against a tag in a single cycle.
// Reports the lowest matching way and the lowest invalid way.
// Assumes: purely combinational; WAY_W is wide enough to index WAYS.
module ltd_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 14,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           want,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       has_free,
    output logic [WAY_W-1:0]           free_way
);
    logic [WAYS-1:0] eq;

    // One comparator per way.
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign eq[w] = vld[w] && (tags[w] == want);
        end
    endgenerate

    // Priority encode match and vacancy, lowest index wins.
    always_comb begin
        hit      = |eq;
        has_free = ~&vld;
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w])   hit_way  = WAY_W'(w);
            if (!vld[w]) free_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/ltd_free_stack.sv
`timescale 1ns/1ps
// Stack of free pool-tag indices. After reset it holds every index.
// Assumes: push and pop never occur in the same cycle, no push when
// full and no pop when empty (the caller guards both).
module ltd_free_stack #(
    parameter int DEPTH = 6,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] top_idx,
    output logic [CNT_W-1:0] count
);
    logic [DEPTH-1:0][IDX_W-1:0] slots;
    logic [CNT_W-1:0]            below;

    assign below   = count - CNT_W'(1);
    assign top_idx = slots[below];

    // Fill with all indices on reset, then track pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= CNT_W'(DEPTH);
            for (int i = 0; i < DEPTH; i++) slots[i] <= IDX_W'(i);
        end else if (push) begin
            slots[count] <= push_idx;
            count        <= count + CNT_W'(1);
        end else if (pop) begin
            count <= below;
        end
    end

endmodule

// File: rtl/linked_tag_dir.sv
`timescale 1ns/1ps
// Linked-tag set directory: primary ways per set plus chains of tags
// borrowed from a shared pool, walked one tag per cycle.
// Assumes: SETS is a power of two and at least 2; one command at a time;
// the caller never inserts a line that is already present.
module linked_tag_dir
    import ltd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SETS      = 4,
    parameter int WAYS      = 2,
    parameter int POOL      = 6,
    parameter int SLOT_W    = 4,
    parameter int MAX_CHAIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SLOT_W-1:0] req_slot,
    output logic              done,
    output logic [1:0]        rsp_status,
    output logic [SLOT_W-1:0] rsp_slot,
    output logic              pool_dry
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int IDX_W = (POOL > 1) ? $clog2(POOL) : 1;
    localparam int LEN_W = $clog2(MAX_CHAIN + 1);
    localparam int CNT_W = $clog2(POOL + 1);

    // Primary ways.
    logic [SETS-1:0][WAYS-1:0]             prim_vld;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  prim_tag;
    logic [SETS-1:0][WAYS-1:0][SLOT_W-1:0] prim_slot;
    // Per-set chain head and length.
    logic [SETS-1:0][IDX_W-1:0]            head;
    logic [SETS-1:0][LEN_W-1:0]            chain_len;
    // Pool tags with next pointers.
    logic [POOL-1:0][TAG_W-1:0]            pool_tag;
    logic [POOL-1:0][SLOT_W-1:0]           pool_slot;
    logic [POOL-1:0][IDX_W-1:0]            pool_nxt;

    // Command in progress.
    phase_e            phase;
    logic [1:0]        r_op;
    logic [SET_W-1:0]  r_set;
    logic [TAG_W-1:0]  r_tag;
    logic [SLOT_W-1:0] r_slot;
    logic [IDX_W-1:0]  cur;
    logic [IDX_W-1:0]  prev;
    logic              prev_vld;
    logic [LEN_W-1:0]  steps;

    // Decision signals.
    logic              p_hit, p_has_free;
    logic [WAY_W-1:0]  p_hit_way, p_free_way;
    logic [LEN_W-1:0]  len_here;
    logic              cur_hit;
    logic              finish, go_walk, ins_prim, pop_en, push_en;
    logic [1:0]        fin_status;
    logic [SLOT_W-1:0] fin_slot;
    logic [IDX_W-1:0]  new_idx;
    logic [CNT_W-1:0]  free_cnt;

    assign req_ready = (phase == PH_IDLE);
    assign pool_dry  = (free_cnt == '0);
    assign len_here  = chain_len[r_set];
    assign cur_hit   = (pool_tag[cur] == r_tag);

    ltd_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) u_match (
        .vld      (prim_vld[r_set]),
        .tags     (prim_tag[r_set]),
        .want     (r_tag),
        .hit      (p_hit),
        .hit_way  (p_hit_way),
        .has_free (p_has_free),
        .free_way (p_free_way)
    );

    ltd_free_stack #(
        .DEPTH (POOL),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_en),
        .push_idx (cur),
        .pop      (pop_en),
        .top_idx  (new_idx),
        .count    (free_cnt)
    );

    // Decide the outcome of the current phase.
    always_comb begin
        finish     = 1'b0;
        fin_status = ST_OK;
        fin_slot   = '0;
        go_walk    = 1'b0;
        ins_prim   = 1'b0;
        pop_en     = 1'b0;
        push_en    = 1'b0;
        case (phase)
            PH_PRIMARY: begin
                if (r_op == OP_INSERT) begin
                    finish   = 1'b1;
                    fin_slot = r_slot;
                    if (p_has_free)                           ins_prim   = 1'b1;
                    else if (len_here == LEN_W'(MAX_CHAIN))   fin_status = ST_CHAINFULL;
                    else if (free_cnt == '0)                  fin_status = ST_NOSPACE;
                    else                                      pop_en     = 1'b1;
                end else if (p_hit) begin
                    finish   = 1'b1;
                    fin_slot = prim_slot[r_set][p_hit_way];
                end else if (len_here == '0) begin
                    finish     = 1'b1;
                    fin_status = ST_MISS;
                end else begin
                    go_walk = 1'b1;
                end
            end
            PH_WALK: begin
                if (cur_hit) begin
                    finish   = 1'b1;
                    fin_slot = pool_slot[cur];
                    push_en  = (r_op == OP_REMOVE);
                end else if (steps == len_here) begin
                    finish     = 1'b1;
                    fin_status = ST_MISS;
                end
            end
            default: ;
        endcase
    end

    // Sequence phases, update the directory and register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            done       <= 1'b0;
            rsp_status <= ST_OK;
            rsp_slot   <= '0;
            prim_vld   <= '0;
            chain_len  <= '0;
            prev_vld   <= 1'b0;
            steps      <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                rsp_status <= fin_status;
                rsp_slot   <= fin_slot;
            end
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        r_op   <= req_op;
                        r_set  <= req_addr[SET_W-1:0];
                        r_tag  <= req_addr[ADDR_W-1:SET_W];
                        r_slot <= req_slot;
                        phase  <= PH_PRIMARY;
                    end
                end
                PH_PRIMARY: begin
                    if (ins_prim) begin
                        prim_vld[r_set][p_free_way]  <= 1'b1;
                        prim_tag[r_set][p_free_way]  <= r_tag;
                        prim_slot[r_set][p_free_way] <= r_slot;
                    end
                    if (pop_en) begin
                        pool_tag[new_idx]  <= r_tag;
                        pool_slot[new_idx] <= r_slot;
                        pool_nxt[new_idx]  <= head[r_set];
                        head[r_set]        <= new_idx;
                        chain_len[r_set]   <= len_here + LEN_W'(1);
                    end
                    if (r_op == OP_REMOVE && p_hit) prim_vld[r_set][p_hit_way] <= 1'b0;
                    if (go_walk) begin
                        cur      <= head[r_set];
                        prev_vld <= 1'b0;
                        steps    <= LEN_W'(1);
                        phase    <= PH_WALK;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                PH_WALK: begin
                    if (push_en) begin
                        if (prev_vld) pool_nxt[prev] <= pool_nxt[cur];
                        else          head[r_set]    <= pool_nxt[cur];
                        chain_len[r_set] <= len_here - LEN_W'(1);
                    end
                    if (finish) begin
                        phase <= PH_IDLE;
                    end else begin
                        prev     <= cur;
                        prev_vld <= 1'b1;
                        cur      <= pool_nxt[cur];
                        steps    <= steps + LEN_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/linked_tag_dir_chk.sv
`timescale 1ns/1ps
// Property checker for the linked-tag set directory, bound to the top.
// Assumes: sees the top's ports plus its free count and chain lengths.
module linked_tag_dir_chk #(
    parameter int SETS      = 4,
    parameter int POOL      = 6,
    parameter int MAX_CHAIN = 3,
    parameter int LEN_W     = 2,
    parameter int CNT_W     = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       done,
    input logic [1:0]                 rsp_status,
    input logic                       pool_dry,
    input logic [CNT_W-1:0]           free_cnt,
    input logic [SETS-1:0][LEN_W-1:0] chain_len
);
    int         used_total;
    int         longest;
    logic [7:0] busy_cnt;

    // Total borrowed tags and the longest chain.
    always_comb begin
        used_total = 0;
        longest    = 0;
        for (int s = 0; s < SETS; s++) begin
            used_total += int'(chain_len[s]);
            if (int'(chain_len[s]) > longest) longest = int'(chain_len[s]);
        end
    end

    // Cycles spent with a command in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_cnt <= '0;
        else if (req_ready) busy_cnt <= '0;
        else                busy_cnt <= busy_cnt + 8'd1;
    end

    assert_single_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_tag_conservation_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_cnt) + used_total) == POOL);

    assert_chain_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        longest <= MAX_CHAIN);

    assert_nospace_when_dry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_status == 2'd2) |-> $past(pool_dry));

    assert_bounded_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        int'(busy_cnt) <= MAX_CHAIN + 1);

endmodule

bind linked_tag_dir linked_tag_dir_chk #(
    .SETS      (SETS),
    .POOL      (POOL),
    .MAX_CHAIN (MAX_CHAIN),
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/linked_tag_dir_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, the monitor
// compares status, slot and latency whenever done pulses.
module linked_tag_dir_test;
    localparam int ADDR_W = 16, SETS = 4, WAYS = 2, POOL = 6, SLOT_W = 4, MAX_CHAIN = 3;
    localparam int SET_W = 2;
    localparam int OK = 0, MISS = 1, NOSPACE = 2, FULL = 3;
    localparam int LK = 0, INS = 1, REM = 2, LK3 = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SLOT_W-1:0] req_slot = '0;
    logic              done;
    logic [1:0]        rsp_status;
    logic [SLOT_W-1:0] rsp_slot;
    logic              pool_dry;

    int n_checks = 0;
    int n_fail   = 0;
    int q_status[$];
    int q_slot[$];
    int q_lat[$];
    string q_req[$];
    int ncyc = 0;
    int acc_cyc = 0;
    logic prev_done = 1'b0;

    linked_tag_dir #(
        .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS),
        .POOL(POOL), .SLOT_W(SLOT_W), .MAX_CHAIN(MAX_CHAIN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_slot(req_slot),
        .done(done), .rsp_status(rsp_status), .rsp_slot(rsp_slot), .pool_dry(pool_dry)
    );

    always #10 clk = ~clk;

    function automatic logic [ADDR_W-1:0] mk(int tag, int set);
        return ADDR_W'((tag << SET_W) | set);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: compare each completion against the front of the scoreboard.
    always @(negedge clk) begin : monitor
        int es;
        int esl;
        int el;
        string rq;
        ncyc = ncyc + 1;
        if (done) begin
            check(!prev_done, "R11", "done held two cycles", 1, 0);
            if (q_status.size() == 0) begin
                check(1'b0, "R11", "unexpected done", 1, 0);
            end else begin
                es  = q_status.pop_front();
                esl = q_slot.pop_front();
                el  = q_lat.pop_front();
                rq  = q_req.pop_front();
                check(int'(rsp_status) == es, rq, "status", int'(rsp_status), es);
                if (esl >= 0) check(int'(rsp_slot) == esl, rq, "slot", int'(rsp_slot), esl);
                check((ncyc - acc_cyc - 1) == el, rq, "latency", ncyc - acc_cyc - 1, el);
            end
        end
        prev_done = done;
        if (rst_n && req_valid && req_ready) acc_cyc = ncyc;
    end

    // Driver: wait for ready, present one command for one edge, queue expectation.
    task automatic issue(int op, int tag, int set, int slot, int est, int eslot, int elat, string req);
        while (!req_ready) begin @(posedge clk); #2; end
        req_op    = 2'(op);
        req_addr  = mk(tag, set);
        req_slot  = SLOT_W'(slot);
        req_valid = 1'b1;
        q_status.push_back(est);
        q_slot.push_back(eslot);
        q_lat.push_back(elat);
        q_req.push_back(req);
        @(posedge clk); #2;
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11", "ready after accept", int'(req_ready), 0);
    endtask

    task automatic drain();
        while (q_status.size() != 0 || !req_ready) begin @(posedge clk); #2; end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        finish_run();
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        check(pool_dry == 1'b0, "R1", "pool_dry after reset", int'(pool_dry), 0);
        issue(LK, 5, 0, 0, MISS, -1, 1, "R1");

        // Primary ways.
        issue(INS, 5, 0, 1, OK, 1, 1, "R3");
        issue(INS, 6, 0, 2, OK, 2, 1, "R3");
        issue(LK, 5, 0, 0, OK, 1, 1, "R5");
        issue(LK3, 6, 0, 0, OK, 2, 1, "R5");
        issue(LK, 5, 1, 0, MISS, -1, 1, "R2");

        // Chain growth, newest first: 9, 8, 7.
        issue(INS, 7, 0, 3, OK, 3, 1, "R4");
        issue(INS, 8, 0, 4, OK, 4, 1, "R4");
        issue(INS, 9, 0, 5, OK, 5, 1, "R4");
        issue(LK, 9, 0, 0, OK, 5, 2, "R6");
        issue(LK, 8, 0, 0, OK, 4, 3, "R6");
        issue(LK, 7, 0, 0, OK, 3, 4, "R6");
        issue(LK, 10, 0, 0, MISS, -1, 4, "R6");

        // Chain at limit.
        issue(INS, 10, 0, 6, FULL, -1, 1, "R7");
        issue(LK, 10, 0, 0, MISS, -1, 4, "R7");
        drain();
        check(pool_dry == 1'b0, "R7", "pool_dry after refused insert", int'(pool_dry), 0);

        // Drain the pool through set 1.
        issue(INS, 1, 1, 7, OK, 7, 1, "R3");
        issue(INS, 2, 1, 8, OK, 8, 1, "R3");
        issue(INS, 3, 1, 9, OK, 9, 1, "R4");
        issue(INS, 4, 1, 10, OK, 10, 1, "R4");
        drain();
        check(pool_dry == 1'b0, "R8", "pool_dry with one tag left", int'(pool_dry), 0);
        issue(INS, 11, 1, 11, OK, 11, 1, "R4");
        drain();
        check(pool_dry == 1'b1, "R8", "pool_dry when exhausted", int'(pool_dry), 1);
        issue(INS, 12, 2, 12, OK, 12, 1, "R3");
        issue(INS, 13, 2, 13, OK, 13, 1, "R3");
        issue(INS, 14, 2, 14, NOSPACE, -1, 1, "R8");
        issue(LK, 14, 2, 0, MISS, -1, 1, "R8");

        // Unlink from the middle, then from the head.
        issue(REM, 8, 0, 0, OK, 4, 3, "R10");
        drain();
        check(pool_dry == 1'b0, "R10", "pool_dry after unlink", int'(pool_dry), 0);
        issue(LK, 7, 0, 0, OK, 3, 3, "R10");
        issue(LK, 9, 0, 0, OK, 5, 2, "R10");
        issue(LK, 8, 0, 0, MISS, -1, 3, "R9");
        issue(REM, 9, 0, 0, OK, 5, 2, "R10");
        issue(LK, 7, 0, 0, OK, 3, 2, "R10");
        issue(INS, 14, 2, 14, OK, 14, 1, "R10");
        issue(LK, 14, 2, 0, OK, 14, 2, "R4");

        // Primary removal and refill.
        issue(REM, 5, 0, 0, OK, 1, 1, "R9");
        issue(LK, 5, 0, 0, MISS, -1, 2, "R9");
        issue(INS, 15, 0, 15, OK, 15, 1, "R3");
        issue(LK, 16, 0, 0, MISS, -1, 2, "R3");
        issue(LK, 15, 0, 0, OK, 15, 1, "R3");
        issue(REM, 13, 3, 0, MISS, -1, 1, "R9");

        // Request while busy is ignored: set 1 chain is 11, 4, 3.
        issue(LK, 3, 1, 0, OK, 9, 4, "R6");
        req_op    = 2'(REM);
        req_addr  = mk(1, 1);
        req_valid = 1'b1;
        @(posedge clk); #2;
        @(posedge clk); #2;
        req_valid = 1'b0;
        drain();
        issue(LK, 1, 1, 0, OK, 7, 1, "R11");
        drain();
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule